// File: doc/BRIEF.md
# Command Method Decoder

This block sits behind a command queue and turns each method/data pair into an action. The method index comes from the low 11 bits of the method word. The block looks that index up in a fixed, ascending table of seven index ranges and checks one range per clock. A matching slot either stores the data word in a state register file or fires a one-cycle command strobe toward a downstream executor. Each slot has its own mask of data bits that may be set. Data that sets a bit outside the mask is rejected, and so is any index outside every range.

On a rejection the block captures an error word and the offending data word in two holding registers. It then raises a host interrupt and stays stalled, with its input closed, until the host acknowledges. Every accepted method ends with a one-cycle completion pulse, whether it succeeded or failed. The executor reads stored state through a combinational read port.

Top module: `cmd_method_decoder`

## Requirements
- R1: After reset, `in_ready` is 1, `host_irq`, `done` and `cmd_strobe` are 0, `err_word` and `err_data` are 0, and every state slot reads 0.
- R2: Only bits [10:0] of `in_method` form the method index. Bits above bit 10 have no effect on the result.
- R3: Valid data written to a state index is stored in slot `rd_sel` as follows: index 0x000 goes to slot 0, 0x080+k to slot 1+k (k<7), 0x088+k to slot 8+k (k<7), and 0x0C3+k to slot 15+k (k<14). A command index writes no slot.
- R4: Command indices produce a one-cycle `cmd_strobe` in the same cycle as `done`, with `cmd_data` equal to the data word. `cmd_sel` is 0 for 0x040, 1 for 0x050, 2 for 0x0C0 and 3 for 0x0C1.
- R5: An index outside every range sets `err_word` to (index << 16) | 1 and `err_data` to the data word. It raises `host_irq` and changes no slot.
- R6: Data with a bit outside its slot mask sets `err_word` to (index << 16) | 3, captures the data and raises `host_irq`, and the slot keeps its old value. Masks: slot 0 all bits. Tile slots k=0..6 (source and destination alike): 0xFFF, 0x7FFFF, 0x1FFF, 0x7FF, 0xFFF, 0x7FFFF, 0x1FFF. Group slots k=0..13: 0xFF, all, 0xFF, all, 0x7FFFF, 0x7FFFF, 0xFFFF, 0x1FFF, 0x0333FFFF, all, all, 0xFF, all, all. Commands: all bits.
- R7: `host_irq` stays high and `in_ready` stays low until `host_ack` is sampled high. On that edge `host_irq` falls and `done` pulses. `host_ack` while no interrupt is pending has no effect.
- R8: `done` is a single-cycle pulse, given exactly once per accepted method.
- R9: `in_ready` is low from the accepting edge until `done`. Data is captured on the accepting edge, so later changes on `in_data` do not affect the result.
- R10: The ranges are checked in ascending order (starts 0x000, 0x040, 0x050, 0x080, 0x088, 0x0C0, 0x0C3), one per clock. A method resolved at range r (0-based) gives `done`, or `host_irq` on error, r+1 cycles after acceptance. An index above the last range resolves at range 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Method/data pair offered |
| in_ready | output | 1 | Decoder can accept a pair |
| in_method | input | METHOD_W | Method word; low 11 bits are the index |
| in_data | input | 32 | Data word for the method |
| cmd_strobe | output | 1 | One-cycle command pulse |
| cmd_sel | output | 2 | Which command fired |
| cmd_data | output | 32 | Data word carried with the command |
| done | output | 1 | One-cycle completion pulse per method |
| rd_sel | input | 5 | State slot to read |
| rd_data | output | 32 | Contents of the selected slot |
| err_word | output | 32 | Captured error word |
| err_data | output | 32 | Captured offending data |
| host_irq | output | 1 | Error interrupt, held until acknowledged |
| host_ack | input | 1 | Host acknowledge of the interrupt |

## Verification
The bench probes the edges of each range: the index just past the last slot of a group (0x0C2 and 0x0D1), indices below the first command, and the top index 0x7FF. A decoder with an off-by-one range end would store into a neighbouring slot or accept a gap index instead of raising code 1. Masks are tested with a data bit one position above the allowed field, and with the all-bits slot and the split format mask at full width. A wrong mask would either flag legal data or let the bad word overwrite the slot. The bench also changes `in_data` right after acceptance and toggles the acknowledge while idle. This catches a design that samples data late or lets a stray acknowledge produce a spurious completion.

// File: rtl/cmdec_pkg.sv
package cmdec_pkg;
  localparam int IDX_W      = 11;
  localparam int DATA_W     = 32;
  localparam int CNT_W      = 5;
  localparam int NUM_RANGES = 7;
  localparam int RNG_W      = $clog2(NUM_RANGES + 1);
  localparam int NUM_SLOTS  = 29;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int NUM_CMDS   = 4;
  localparam int CMD_W      = $clog2(NUM_CMDS);
  localparam int TILE_N     = 7;
  localparam int GROUP_N    = 14;
  localparam logic [1:0] CODE_UNKNOWN = 2'd1;
  localparam logic [1:0] CODE_BADBITS = 2'd3;

  typedef struct packed {
    logic [IDX_W-1:0]  start;
    logic [CNT_W-1:0]  count;
    logic              is_cmd;
    logic [SLOT_W-1:0] base;
  } range_t;

  typedef enum logic [1:0] {WALK_NEXT, WALK_HIT, WALK_MISS} walk_t;
  typedef enum logic [1:0] {PH_IDLE, PH_SEARCH, PH_HOLD} phase_t;

  // Ascending range table; base is a slot number or a command number.
  function automatic range_t range_entry(input logic [RNG_W-1:0] r);
    range_t e;
    case (r)
      3'd0: e = '{start: 11'h000, count: 5'd1,  is_cmd: 1'b0, base: 5'd0};
      3'd1: e = '{start: 11'h040, count: 5'd1,  is_cmd: 1'b1, base: 5'd0};
      3'd2: e = '{start: 11'h050, count: 5'd1,  is_cmd: 1'b1, base: 5'd1};
      3'd3: e = '{start: 11'h080, count: 5'd7,  is_cmd: 1'b0, base: 5'd1};
      3'd4: e = '{start: 11'h088, count: 5'd7,  is_cmd: 1'b0, base: 5'd8};
      3'd5: e = '{start: 11'h0C0, count: 5'd2,  is_cmd: 1'b1, base: 5'd2};
      3'd6: e = '{start: 11'h0C3, count: 5'd14, is_cmd: 1'b0, base: 5'd15};
      default: e = '{start: 11'h7FF, count: 5'd0, is_cmd: 1'b0, base: 5'd0};
    endcase
    return e;
  endfunction

  function automatic logic [DATA_W-1:0] tile_mask(input logic [2:0] k);
    logic [DATA_W-1:0] m;
    case (k)
      3'd0, 3'd4: m = 32'h0000_0FFF;
      3'd1, 3'd5: m = 32'h0007_FFFF;
      3'd2, 3'd6: m = 32'h0000_1FFF;
      3'd3:       m = 32'h0000_07FF;
      default:    m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] group_mask(input logic [3:0] k);
    logic [DATA_W-1:0] m;
    case (k)
      4'd0, 4'd2, 4'd11: m = 32'h0000_00FF;
      4'd4, 4'd5:        m = 32'h0007_FFFF;
      4'd6:              m = 32'h0000_FFFF;
      4'd7:              m = 32'h0000_1FFF;
      4'd8:              m = 32'h0333_FFFF;
      4'd1, 4'd3, 4'd9, 4'd10, 4'd12, 4'd13: m = '1;
      default:           m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] slot_mask(input logic [SLOT_W-1:0] s);
    logic [SLOT_W-1:0] rel;
    logic [DATA_W-1:0] m;
    if (s == '0) begin
      rel = '0;
      m   = '1;
    end else if (s <= SLOT_W'(TILE_N)) begin
      rel = s - SLOT_W'(1);
      m   = tile_mask(rel[2:0]);
    end else if (s <= SLOT_W'(2 * TILE_N)) begin
      rel = s - SLOT_W'(TILE_N + 1);
      m   = tile_mask(rel[2:0]);
    end else begin
      rel = s - SLOT_W'(2 * TILE_N + 1);
      m   = group_mask(rel[3:0]);
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] make_err_word(input logic [IDX_W-1:0] idx,
                                                      input logic [1:0] code);
    logic [DATA_W-1:0] w;
    w = '0;
    w[16 +: IDX_W] = idx;
    w[1:0] = code;
    return w;
  endfunction
endpackage

// File: rtl/cmdec_range_walk.sv
module cmdec_range_walk
  import cmdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [IDX_W-1:0]  idx,
  output walk_t             outcome,
  output logic [SLOT_W-1:0] pos,
  output logic              is_cmd
);
  logic [RNG_W-1:0] rng;
  range_t           ent;
  logic [IDX_W:0]   upper;
  logic [IDX_W-1:0] offs_unused_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rng <= '0;
    else if (load) rng <= '0;
    else if (step) rng <= rng + RNG_W'(1);
  end

  always_comb begin
    ent            = range_entry(rng);
    upper          = {1'b0, ent.start} + {{(IDX_W + 1 - CNT_W){1'b0}}, ent.count};
    offs_unused_hi = idx - ent.start;
    pos            = ent.base + offs_unused_hi[SLOT_W-1:0];
    is_cmd         = ent.is_cmd;
    if (idx < ent.start)                     outcome = WALK_MISS;
    else if ({1'b0, idx} < upper)            outcome = WALK_HIT;
    else if (rng == RNG_W'(NUM_RANGES - 1))  outcome = WALK_MISS;
    else                                     outcome = WALK_NEXT;
  end
endmodule

// File: rtl/cmdec_state_file.sv
module cmdec_state_file
  import cmdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SLOT_W-1:0] rsel,
  output logic [DATA_W-1:0] rdata
);
  logic [NUM_SLOTS*DATA_W-1:0] flat;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (we && wsel == SLOT_W'(g))   q <= wdata;
    end
    assign flat[g*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    if (rsel < SLOT_W'(NUM_SLOTS)) rdata = flat[rsel*DATA_W +: DATA_W];
    else                           rdata = '0;
  end
endmodule

// File: rtl/cmdec_err_capture.sv
module cmdec_err_capture
  import cmdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] word_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ack,
  output logic              irq,
  output logic              released,
  output logic [DATA_W-1:0] word_q,
  output logic [DATA_W-1:0] data_q
);
  assign released = irq && ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      word_q <= '0;
      data_q <= '0;
    end else if (capture) begin
      irq    <= 1'b1;
      word_q <= word_in;
      data_q <= data_in;
    end else if (released) begin
      irq    <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_method_decoder.sv
module cmd_method_decoder
  import cmdec_pkg::*;
#(
  parameter int METHOD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [METHOD_W-1:0] in_method,
  input  logic [DATA_W-1:0]   in_data,
  output logic                cmd_strobe,
  output logic [CMD_W-1:0]    cmd_sel,
  output logic [DATA_W-1:0]   cmd_data,
  output logic                done,
  input  logic [SLOT_W-1:0]   rd_sel,
  output logic [DATA_W-1:0]   rd_data,
  output logic [DATA_W-1:0]   err_word,
  output logic [DATA_W-1:0]   err_data,
  output logic                host_irq,
  input  logic                host_ack
);
  phase_t            phase, phase_nx;
  logic [IDX_W-1:0]  cap_idx;
  logic [DATA_W-1:0] cap_data;
  logic              accept, searching;
  walk_t             outcome;
  logic [SLOT_W-1:0] pos;
  logic              is_cmd;
  logic [DATA_W-1:0] allow;
  logic              bad_bits, found, miss_ev;
  logic              err_fire, st_we, cmd_fire, released;
  logic [1:0]        err_code;
  logic              unused_hi;

  assign unused_hi = ^in_method[METHOD_W-1:IDX_W];

  assign in_ready  = (phase == PH_IDLE);
  assign accept    = in_valid && in_ready;
  assign searching = (phase == PH_SEARCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_idx  <= '0;
      cap_data <= '0;
    end else if (accept) begin
      cap_idx  <= in_method[IDX_W-1:0];
      cap_data <= in_data;
    end
  end

  cmdec_range_walk u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .step    (searching && outcome == WALK_NEXT),
    .idx     (cap_idx),
    .outcome (outcome),
    .pos     (pos),
    .is_cmd  (is_cmd)
  );

  always_comb begin
    allow    = is_cmd ? {DATA_W{1'b1}} : slot_mask(pos);
    bad_bits = |(cap_data & ~allow);
    found    = searching && outcome == WALK_HIT;
    miss_ev  = searching && outcome == WALK_MISS;
    err_fire = miss_ev || (found && bad_bits);
    err_code = miss_ev ? CODE_UNKNOWN : CODE_BADBITS;
    st_we    = found && !bad_bits && !is_cmd;
    cmd_fire = found && !bad_bits && is_cmd;
  end

  cmdec_state_file u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_we),
    .wsel  (pos),
    .wdata (cap_data),
    .rsel  (rd_sel),
    .rdata (rd_data)
  );

  cmdec_err_capture u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (err_fire),
    .word_in  (make_err_word(cap_idx, err_code)),
    .data_in  (cap_data),
    .ack      (host_ack),
    .irq      (host_irq),
    .released (released),
    .word_q   (err_word),
    .data_q   (err_data)
  );

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE:   if (accept) phase_nx = PH_SEARCH;
      PH_SEARCH: begin
        if (err_fire)               phase_nx = PH_HOLD;
        else if (st_we || cmd_fire) phase_nx = PH_IDLE;
      end
      PH_HOLD:   if (released) phase_nx = PH_IDLE;
      default:   phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      done       <= 1'b0;
      cmd_strobe <= 1'b0;
      cmd_sel    <= '0;
      cmd_data   <= '0;
    end else begin
      phase      <= phase_nx;
      done       <= st_we || cmd_fire || (phase == PH_HOLD && released);
      cmd_strobe <= cmd_fire;
      if (cmd_fire) begin
        cmd_sel  <= pos[CMD_W-1:0];
        cmd_data <= cap_data;
      end
    end
  end
endmodule

// File: rtl/cmdec_checker.sv
module cmdec_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       done,
  input logic       cmd_strobe,
  input logic       host_irq,
  input logic       host_ack,
  input logic [1:0] err_code,
  input logic       st_we
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_STROBE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> done); // R4
  AST_STATE_WRITE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> (done && !cmd_strobe)); // R3
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && !host_ack) |=> host_irq); // R7
  AST_IRQ_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> !in_ready); // R7
  AST_IRQ_RELEASE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_irq) |-> done); // R7
  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R9
  AST_ERR_CODE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> (err_code == 2'd1 || err_code == 2'd3)); // R5
endmodule

bind cmd_method_decoder cmdec_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .done       (done),
  .cmd_strobe (cmd_strobe),
  .host_irq   (host_irq),
  .host_ack   (host_ack),
  .err_code   (err_word[1:0]),
  .st_we      (st_we)
);

// File: tb/sim_cmd_method_decoder.sv
`timescale 1ns/1ps
module sim_cmd_method_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_method = '0;
  logic [31:0] in_data = '0;
  logic        cmd_strobe;
  logic [1:0]  cmd_sel;
  logic [31:0] cmd_data;
  logic        done;
  logic [4:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [31:0] err_word, err_data;
  logic        host_irq;
  logic        host_ack = 1'b0;

  int total = 0;
  int bad = 0;
  int g_lat, g_irq_lat;
  bit g_strobe, g_ready_bad, g_after_done, g_finished;
  logic [1:0]  g_sel;
  logic [31:0] g_sdata, g_ew, g_ed;

  always #2.5 clk = ~clk;

  cmd_method_decoder u0 (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_lat(input int idx);
    int st[7] = '{'h000, 'h040, 'h050, 'h080, 'h088, 'h0C0, 'h0C3};
    int ln[7] = '{1, 1, 1, 7, 7, 2, 14};
    for (int r = 0; r < 7; r++)
      if (idx < st[r] + ln[r]) return r + 1;
    return 7;
  endfunction

  function automatic logic [31:0] ew(input int idx, input int code);
    return (32'(idx) << 16) | 32'(code);
  endfunction

  task automatic read_slot(input int s, output logic [31:0] v);
    rd_sel = 5'(s);
    #1 v = rd_data;
  endtask

  task automatic issue(input logic [31:0] m, input logic [31:0] d);
    int irq_cycles = 0;
    g_lat = 0; g_irq_lat = 0; g_strobe = 0; g_ready_bad = 0;
    @(negedge clk);
    in_method = m; in_data = d; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0; in_data = ~d; in_method = '0;
    for (int n = 0; n < 60; n++) begin
      @(posedge clk); #1;
      g_lat++;
      if (done) begin
        g_strobe = cmd_strobe; g_sel = cmd_sel; g_sdata = cmd_data;
        break;
      end
      if (in_ready) g_ready_bad = 1;
      if (host_irq) begin
        if (g_irq_lat == 0) begin
          g_irq_lat = g_lat; g_ew = err_word; g_ed = err_data;
        end
        irq_cycles++;
        host_ack = (irq_cycles == 4);
      end
    end
    host_ack = 1'b0;
    if (!done) chk("R8", "method never completed", 32'(done), 32'd1);
    @(posedge clk); #1 g_after_done = done;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1", "in_ready", 32'(in_ready), 32'd1);
    chk("R1", "host_irq", 32'(host_irq), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "cmd_strobe", 32'(cmd_strobe), 32'd0);
    chk("R1", "err_word", err_word, 32'd0);
    chk("R1", "err_data", err_data, 32'd0);
    read_slot(0, v);  chk("R1", "slot0", v, 32'd0);
    read_slot(28, v); chk("R1", "slot28", v, 32'd0);
  endtask

  task automatic do_store(input int idx, input logic [31:0] d, input int slot);
    logic [31:0] v;
    issue(32'(idx), d);
    chk("R3", $sformatf("no strobe idx %0h", idx), 32'(g_strobe), 32'd0);
    chk("R10", $sformatf("latency idx %0h", idx), 32'(g_lat), 32'(exp_lat(idx)));
    chk("R9", $sformatf("ready low idx %0h", idx), 32'(g_ready_bad), 32'd0);
    read_slot(slot, v);
    chk("R3", $sformatf("slot %0d", slot), v, d);
  endtask

  task automatic t_state_writes();
    do_store('h000, 32'hDEAD_BEEF, 0);
    chk("R8", "done single pulse", 32'(g_after_done), 32'd0);
    do_store('h081, 32'h0007_FFFF, 2);
    do_store('h08E, 32'h0000_1FFF, 14);
    do_store('h0D0, 32'hFFFF_FFFF, 28);
    do_store('h0CB, 32'h0333_FFFF, 23);
    do_store('h080, 32'h0000_0ABC, 1);
  endtask

  task automatic do_cmd(input int idx, input logic [31:0] d, input int sel);
    issue(32'(idx), d);
    chk("R4", $sformatf("strobe idx %0h", idx), 32'(g_strobe), 32'd1);
    chk("R4", $sformatf("sel idx %0h", idx), 32'(g_sel), 32'(sel));
    chk("R4", $sformatf("data idx %0h", idx), g_sdata, d);
    chk("R10", $sformatf("latency idx %0h", idx), 32'(g_lat), 32'(exp_lat(idx)));
    chk("R4", "strobe one cycle", 32'(cmd_strobe), 32'd0);
  endtask

  task automatic t_commands();
    logic [31:0] v;
    do_cmd('h040, 32'h0000_0005, 0);
    do_cmd('h050, 32'hFFFF_0000, 1);
    do_cmd('h0C0, 32'h0000_1111, 2);
    do_cmd('h0C1, 32'h8000_0001, 3);
    read_slot(0, v);  chk("R4", "cmd left slot0", v, 32'hDEAD_BEEF);
    read_slot(28, v); chk("R4", "cmd left slot28", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_upper_bits();
    logic [31:0] v;
    issue(32'hFFFF_F840, 32'h0000_0077);
    chk("R2", "upper bits nop strobe", 32'(g_strobe), 32'd1);
    chk("R2", "upper bits nop sel", 32'(g_sel), 32'd0);
    issue(32'hABCD_0880, 32'h0000_0123);
    read_slot(1, v); chk("R2", "upper bits slot1", v, 32'h0000_0123);
  endtask

  task automatic do_err(input int idx, input logic [31:0] d, input int code,
                        input string req);
    issue(32'(idx), d);
    chk(req, $sformatf("err_word idx %0h", idx), g_ew, ew(idx, code));
    chk(req, $sformatf("err_data idx %0h", idx), g_ed, d);
    chk("R10", $sformatf("irq latency idx %0h", idx), 32'(g_irq_lat), 32'(exp_lat(idx)));
    chk("R7", $sformatf("ready held low idx %0h", idx), 32'(g_ready_bad), 32'd0);
    chk("R7", $sformatf("irq dropped idx %0h", idx), 32'(host_irq), 32'd0);
    chk("R7", $sformatf("done after ack idx %0h", idx), 32'(g_lat), 32'(exp_lat(idx) + 4));
    chk("R5", "no strobe on error", 32'(g_strobe), 32'd0);
  endtask

  task automatic t_illegal();
    logic [31:0] v;
    do_err('h001, 32'h1234_5678, 1, "R5");
    do_err('h0C2, 32'h0000_0001, 1, "R5");
    do_err('h0D1, 32'hCAFE_0000, 1, "R5");
    do_err('h7FF, 32'h0000_00FF, 1, "R5");
    read_slot(28, v); chk("R5", "slot28 untouched", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_bitfield();
    logic [31:0] v;
    do_err('h080, 32'h0000_1000, 3, "R6");
    read_slot(1, v); chk("R6", "slot1 kept", v, 32'h0000_0123);
    do_err('h0CB, 32'h0400_0000, 3, "R6");
    read_slot(23, v); chk("R6", "slot23 kept", v, 32'h0333_FFFF);
    do_err('h0C3, 32'h0000_0100, 3, "R6");
    do_err('h08B, 32'h0000_0800, 3, "R6");
  endtask

  task automatic t_stray_ack();
    @(negedge clk); host_ack = 1'b1;
    @(negedge clk); host_ack = 1'b0;
    @(posedge clk); #1;
    chk("R7", "stray ack irq", 32'(host_irq), 32'd0);
    chk("R7", "stray ack done", 32'(done), 32'd0);
    chk("R7", "stray ack ready", 32'(in_ready), 32'd1);
  endtask

  initial begin
    g_finished = 0;
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_stray_ack();
    t_state_writes();
    t_commands();
    t_upper_bits();
    t_illegal();
    t_bitfield();
    g_finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!g_finished) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule